// File: doc/BRIEF.md
# Shared-Bus Display DRAM Controller

This block sequences a display memory built from 256-row by 64-column, four-bit-wide dynamic RAMs. Each location holds a 12-bit word: an 8-bit waveform byte spread over two nibble lanes, and a 4-bit attribute nibble. The attribute nibble carries the print intensity and the end-of-record mark. A display reader and a host processor share the memory. The display side owns it by default. It hands the memory to the host by raising a grant line, and its own display reads keep every row refreshed while it owns the memory.

A host access carries one 16-bit address word. The two top bits must select the display-memory window, the next six bits give the column, and the low eight bits give the row. The controller drives the row onto the shared 8-bit multiplexed address bus while the row strobe falls. It then drives the column, placed in the middle six bits of the same bus, while the column strobe falls. After a data phase and a precharge it signals completion. A byte-wide host transfer uses the waveform lanes and a nibble-wide transfer uses the attribute lanes. The host write line sets the direction.

While the host owns the memory, an internal timer inserts row-strobe-only refresh cycles for successive rows. These cycles are spaced so that all 256 rows are touched within the refresh window.

Top module: `dispmem_ctrl`

## Requirements
- R1: While reset is held, the row strobe, column strobe and both write strobes are high (inactive) and the completion pulse is low.
- R2: A host request is served only when address bits [15:14] equal 2'b10 and the grant input is high. Otherwise no column strobe, no write and no completion pulse occur, and memory contents are unchanged.
- R3: Row bits are host address [7:0] and column bits are host address [13:8]. The row is on the bus when the row strobe falls. The column appears on bus bits [6:1], with bits 7 and 0 zero, when the column strobe falls. The column strobe falls only while the row strobe has already been low for at least one cycle.
- R4: An accepted access passes through row, column, data and precharge phases of at least one cycle each. The one-cycle completion pulse appears on the fourth clock edge after the request is sampled, with both strobes high. The row strobe stays high for at least one cycle after it rises.
- R5: A write with the byte-wide select high (1) places the host byte on memory bits [7:0] and pulses write strobe bit 0 only. With the select low (0) it places host bits [3:0] on memory bits [11:8] and pulses write strobe bit 1 only. Writes strobe only while the column strobe is low.
- R6: A read returns memory bits [7:0] when byte-wide, or {4'b0000, memory bits [11:8]} when nibble-wide, on the host read data while the completion pulse is high.
- R7: While the grant is high, the controller issues a refresh cycle with the row strobe low and the column strobe high for successive rows, wrapping 255 to 0. One refresh cycle starts within REF_LIM plus a few cycles of the previous row-strobe fall, so every row is refreshed within REF_WINDOW_CLKS.
- R8: While the grant is low, the controller drives no strobes and its refresh timer restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_grant | input | 1 | Display side permits host ownership |
| host_req | input | 1 | Host request, held until completion |
| host_addr | input | 16 | Host address word (window, column, row) |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_wide | input | 1 | 1 = waveform byte, 0 = attribute nibble |
| host_wdata | input | 8 | Host write data |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Host read data |
| mem_addr | output | 8 | Multiplexed row/column address bus |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 2 | Write strobes: bit 0 waveform lanes, bit 1 attribute lanes |
| mem_wdata | output | 12 | Memory write data |
| mem_rdata | input | 12 | Memory read data |

## Verification
The bench targets the address split. A design that swapped row and column, or failed to shift the column into the middle bits, would store a byte where a behavioural DRAM model finds it at the wrong row and column. Byte and nibble writes to the same location must leave the other lanes intact; a wrong write-strobe mapping would corrupt the byte on an attribute write. Requests outside the window or without the grant are held for tens of cycles. A design that ignored the decode would complete them or change memory. A long idle stretch under host ownership must touch all 256 rows in time, which a timer that stalls, miscounts or does not advance the row pointer would miss.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ROW,
      ST_COL,
      ST_DATA,
      ST_PRE,
      ST_RREF,
      ST_RPRE
   } dmc_state_e;
endpackage

// File: rtl/dmc_decode.sv
module dmc_decode #(
   parameter int AW       = 16,
   parameter int ROW_W    = 8,
   parameter int COL_W    = 6,
   parameter int COL_LSB  = 1,
   parameter int WIN_BITS = 2,
   parameter logic [WIN_BITS-1:0] WIN_SEL = 2'b10
) (
   input  logic [AW-1:0]    addr,
   input  logic             grant,
   output logic             hit,
   output logic [ROW_W-1:0] row,
   output logic [ROW_W-1:0] col_field
);
   logic [COL_W-1:0] col;

   assign hit = grant && (addr[AW-1 -: WIN_BITS] == WIN_SEL);
   assign row = addr[ROW_W-1:0];
   assign col = addr[ROW_W +: COL_W];

   // place the column inside the multiplexed bus at COL_LSB
   for (genvar i = 0; i < ROW_W; i++) begin : g_cf
      if (i >= COL_LSB && i < COL_LSB + COL_W) begin : g_on
         assign col_field[i] = col[i-COL_LSB];
      end else begin : g_off
         assign col_field[i] = 1'b0;
      end
   end
endmodule

// File: rtl/dmc_refresh.sv
module dmc_refresh #(
   parameter int ROW_W   = 8,
   parameter int REF_LIM = 1554
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             grant,
   input  logic             ack,
   output logic             pend,
   output logic [ROW_W-1:0] ref_row
);
   localparam int CW = $clog2(REF_LIM + 1);
   localparam logic [CW-1:0] LAST = CW'(REF_LIM - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         pend    <= 1'b0;
         ref_row <= '0;
      end else if (!grant) begin
         cnt  <= '0;
         pend <= 1'b0;
      end else begin
         if (ack) begin
            pend    <= 1'b0;
            ref_row <= ref_row + 1'b1;
         end
         if (!pend) begin
            if (cnt == LAST) begin
               cnt  <= '0;
               pend <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/dmc_seq.sv
module dmc_seq
   import dmc_pkg::*;
#(
   parameter int ROW_W  = 8,
   parameter int DATA_W = 8,
   parameter int ATTR_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     grant,
   input  logic                     req,
   input  logic                     hit,
   input  logic                     wr,
   input  logic                     wide,
   input  logic [ROW_W-1:0]         row,
   input  logic [ROW_W-1:0]         col_field,
   input  logic                     ref_pend,
   input  logic [ROW_W-1:0]         ref_row,
   input  logic [DATA_W+ATTR_W-1:0] rdata_mem,
   output logic                     ref_ack,
   output logic                     done,
   output logic [DATA_W-1:0]        rdata,
   output logic [ROW_W-1:0]         ma,
   output logic                     ras_n,
   output logic                     cas_n,
   output logic [1:0]               we_n
);
   localparam int MW = DATA_W + ATTR_W;

   dmc_state_e       state;
   logic [ROW_W-1:0] lat_row, lat_col;
   logic             lat_wr, lat_wide;
   logic             in_col;

   assign ref_ack = (state == ST_IDLE) && grant && ref_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         lat_row  <= '0;
         lat_col  <= '0;
         lat_wr   <= 1'b0;
         lat_wide <= 1'b0;
         rdata    <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (ref_ack) begin
                  lat_row <= ref_row;
                  lat_wr  <= 1'b0;
                  state   <= ST_RREF;
               end else if (req && hit) begin
                  lat_row  <= row;
                  lat_col  <= col_field;
                  lat_wr   <= wr;
                  lat_wide <= wide;
                  state    <= ST_ROW;
               end
            end
            ST_ROW:  state <= ST_COL;
            ST_COL:  state <= ST_DATA;
            ST_DATA: begin
               if (!lat_wr) begin
                  rdata <= lat_wide ? rdata_mem[DATA_W-1:0]
                                    : {{(DATA_W-ATTR_W){1'b0}}, rdata_mem[MW-1:DATA_W]};
               end
               state <= ST_PRE;
            end
            ST_PRE:  state <= ST_IDLE;
            ST_RREF: state <= ST_RPRE;
            ST_RPRE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign in_col = (state == ST_COL) || (state == ST_DATA);
   assign ras_n  = !((state == ST_ROW) || in_col || (state == ST_RREF));
   assign cas_n  = !in_col;
   assign ma     = in_col ? lat_col : lat_row;
   assign we_n[0] = !(in_col && lat_wr && lat_wide);
   assign we_n[1] = !(in_col && lat_wr && !lat_wide);
   assign done   = (state == ST_PRE);
endmodule

// File: rtl/dispmem_ctrl.sv
module dispmem_ctrl #(
   parameter int AW              = 16,
   parameter int ROW_W           = 8,
   parameter int COL_W           = 6,
   parameter int COL_LSB         = 1,
   parameter int WIN_BITS        = 2,
   parameter logic [WIN_BITS-1:0] WIN_SEL = 2'b10,
   parameter int DATA_W          = 8,
   parameter int ATTR_W          = 4,
   parameter int REF_WINDOW_CLKS = 400000,
   parameter int REF_GUARD       = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     host_grant,
   input  logic                     host_req,
   input  logic [AW-1:0]            host_addr,
   input  logic                     host_wr,
   input  logic                     host_wide,
   input  logic [DATA_W-1:0]        host_wdata,
   output logic                     host_done,
   output logic [DATA_W-1:0]        host_rdata,
   output logic [ROW_W-1:0]         mem_addr,
   output logic                     mem_ras_n,
   output logic                     mem_cas_n,
   output logic [1:0]               mem_we_n,
   output logic [DATA_W+ATTR_W-1:0] mem_wdata,
   input  logic [DATA_W+ATTR_W-1:0] mem_rdata
);
   localparam int MW      = DATA_W + ATTR_W;
   localparam int LANE_W  = 4;
   localparam int NLANES  = MW / LANE_W;
   localparam int BLANES  = DATA_W / LANE_W;
   localparam int ROWS    = 1 << ROW_W;
   localparam int REF_LIM = REF_WINDOW_CLKS / ROWS - REF_GUARD;

   if (ROW_W + COL_W + WIN_BITS != AW) begin : g_chk_aw
      $error("address word width does not match row, column and window fields");
   end
   if (COL_LSB + COL_W > ROW_W) begin : g_chk_col
      $error("column field does not fit the multiplexed bus");
   end
   if ((DATA_W % LANE_W) != 0 || (ATTR_W % LANE_W) != 0 || ATTR_W >= DATA_W) begin : g_chk_lane
      $error("data and attribute widths must be whole lanes, attribute narrower");
   end
   if (REF_LIM < 2) begin : g_chk_ref
      $error("refresh window too short for the row count");
   end

   logic             hit, ref_pend, ref_ack;
   logic [ROW_W-1:0] row, col_field, ref_row;

   dmc_decode #(
      .AW(AW), .ROW_W(ROW_W), .COL_W(COL_W), .COL_LSB(COL_LSB),
      .WIN_BITS(WIN_BITS), .WIN_SEL(WIN_SEL)
   ) u_dec (
      .addr(host_addr), .grant(host_grant), .hit(hit),
      .row(row), .col_field(col_field)
   );

   dmc_refresh #(.ROW_W(ROW_W), .REF_LIM(REF_LIM)) u_ref (
      .clk(clk), .rst_n(rst_n), .grant(host_grant), .ack(ref_ack),
      .pend(ref_pend), .ref_row(ref_row)
   );

   dmc_seq #(.ROW_W(ROW_W), .DATA_W(DATA_W), .ATTR_W(ATTR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .grant(host_grant), .req(host_req), .hit(hit),
      .wr(host_wr), .wide(host_wide), .row(row), .col_field(col_field),
      .ref_pend(ref_pend), .ref_row(ref_row), .rdata_mem(mem_rdata),
      .ref_ack(ref_ack), .done(host_done), .rdata(host_rdata),
      .ma(mem_addr), .ras_n(mem_ras_n), .cas_n(mem_cas_n), .we_n(mem_we_n)
   );

   // waveform lanes carry the byte, attribute lanes carry its low lanes
   for (genvar k = 0; k < NLANES; k++) begin : g_lane
      if (k < BLANES) begin : g_byte
         assign mem_wdata[k*LANE_W +: LANE_W] = host_wdata[k*LANE_W +: LANE_W];
      end else begin : g_attr
         assign mem_wdata[k*LANE_W +: LANE_W] = host_wdata[(k-BLANES)*LANE_W +: LANE_W];
      end
   end
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
   parameter int REF_LIM = 16
) (
   input logic       clk,
   input logic       rst_n,
   input logic       grant,
   input logic       ras_n,
   input logic       cas_n,
   input logic [1:0] we_n,
   input logic       done
);
   int unsigned since_ras;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_ras <= 0;
      else if (!grant || !ras_n) since_ras <= 0;
      else since_ras <= since_ras + 1;
   end

   a_r3_col_after_row: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n) |-> (!ras_n && $past(!ras_n)));
   a_r4_cas_within_ras: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> !ras_n);
   a_r4_precharge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |=> ras_n);
   a_r4_done_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ras_n && cas_n));
   a_r5_write_in_col: assert property (@(posedge clk) disable iff (!rst_n)
      !(&we_n) |-> (!cas_n && $onehot0(~we_n)));
   a_r7_refresh_bound: assert property (@(posedge clk) disable iff (!rst_n)
      since_ras <= REF_LIM + 8);
   a_r8_strobe_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> $past(grant));
endmodule

bind dispmem_ctrl dmc_checker #(.REF_LIM(REF_LIM)) u_chk (
   .clk(clk), .rst_n(rst_n), .grant(host_grant), .ras_n(mem_ras_n),
   .cas_n(mem_cas_n), .we_n(mem_we_n), .done(host_done)
);

// File: tb/tb_dispmem_ctrl.sv
module tb_dispmem_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int REF_WIN    = 6144;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_grant = 1'b0, host_req = 1'b0, host_wr = 1'b0, host_wide = 1'b0;
   logic [15:0] host_addr = '0;
   logic [7:0]  host_wdata = '0;
   logic        host_done;
   logic [7:0]  host_rdata;
   logic [7:0]  mem_addr;
   logic        mem_ras_n, mem_cas_n;
   logic [1:0]  mem_we_n;
   logic [11:0] mem_wdata;
   logic [11:0] mem_rdata = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dispmem_ctrl #(.REF_WINDOW_CLKS(REF_WIN)) dut (
      .clk(clk), .rst_n(rst_n), .host_grant(host_grant), .host_req(host_req),
      .host_addr(host_addr), .host_wr(host_wr), .host_wide(host_wide),
      .host_wdata(host_wdata), .host_done(host_done), .host_rdata(host_rdata),
      .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
      .mem_we_n(mem_we_n), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   int vectors = 0, miscompares = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural DRAM model
   logic [11:0] dram [int];
   logic        ras_q = 1'b1, cas_q = 1'b1;
   logic [7:0]  row_l = '0, col_ma = '0;
   logic [5:0]  col_l = '0;
   int          ras_falls = 0, cas_falls = 0;
   bit          seen [256];

   function automatic logic [11:0] rd_cell(input int k);
      return dram.exists(k) ? dram[k] : 12'h000;
   endfunction

   always @(posedge clk) begin
      ras_q <= mem_ras_n;
      cas_q <= mem_cas_n;
      if (ras_q && !mem_ras_n) begin
         row_l <= mem_addr;
         seen[mem_addr] = 1'b1;
         ras_falls = ras_falls + 1;
      end
      if (cas_q && !mem_cas_n) begin
         col_l     <= mem_addr[6:1];
         col_ma    <= mem_addr;
         cas_falls = cas_falls + 1;
         mem_rdata <= rd_cell(int'({row_l, mem_addr[6:1]}));
      end
      if (!cas_q && !mem_cas_n && mem_we_n != 2'b11) begin
         automatic int k = int'({row_l, col_l});
         automatic logic [11:0] v = rd_cell(k);
         if (!mem_we_n[0]) v[7:0]  = mem_wdata[7:0];
         if (!mem_we_n[1]) v[11:8] = mem_wdata[11:8];
         dram[k] = v;
      end
   end

   // scoreboard
   logic [8:0] exp_q [$];
   logic [7:0] sh_b [int];
   logic [3:0] sh_a [int];
   int         done_cnt = 0;

   always @(negedge clk) begin
      if (rst_n && host_done) begin
         done_cnt++;
         if (exp_q.size() == 0) chk(1'b0, "R4 unexpected completion", 1, 0);
         else begin
            automatic logic [8:0] e = exp_q.pop_front();
            if (e[8]) chk(host_rdata == e[7:0], "R6 read data", host_rdata, e[7:0]);
         end
      end
   end

   function automatic logic [15:0] mk(input logic [1:0] w, input logic [5:0] c, input logic [7:0] r);
      return {w, c, r};
   endfunction

   task automatic host_op(input logic [15:0] a, input bit wr, input bit wide,
                          input logic [7:0] d, output int lat);
      automatic int k = int'({a[7:0], a[13:8]});
      @(negedge clk);
      host_addr = a; host_wr = wr; host_wide = wide; host_wdata = d; host_req = 1'b1;
      if (wr) begin
         exp_q.push_back(9'h000);
         if (wide) sh_b[k] = d; else sh_a[k] = d[3:0];
      end else begin
         automatic logic [7:0] b  = sh_b.exists(k) ? sh_b[k] : 8'h00;
         automatic logic [3:0] at = sh_a.exists(k) ? sh_a[k] : 4'h0;
         exp_q.push_back({1'b1, wide ? b : {4'h0, at}});
      end
      lat = 0;
      do begin @(negedge clk); lat++; end while (!host_done);
      host_req = 1'b0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int lat;
      logic [15:0] a;
      int d0, c0, r0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(mem_ras_n && mem_cas_n && mem_we_n == 2'b11 && !host_done, "R1 reset outputs",
          {mem_ras_n, mem_cas_n, mem_we_n, host_done}, 5'b11110);
      rst_n = 1'b1;
      @(negedge clk);
      host_grant = 1'b1;

      // R4 latency, R3 split, R5 byte write
      a = mk(2'b10, 6'h2B, 8'h5A);
      host_op(a, 1'b1, 1'b1, 8'hC3, lat);
      chk(lat == 4, "R4 completion latency", lat, 4);
      chk(row_l == 8'h5A, "R3 row on bus", row_l, 8'h5A);
      chk(col_ma == {1'b0, 6'h2B, 1'b0}, "R3 column in middle bits", col_ma, {1'b0, 6'h2B, 1'b0});
      chk(rd_cell(int'({8'h5A, 6'h2B})) == 12'h0C3, "R5 byte lanes", rd_cell(int'({8'h5A, 6'h2B})), 12'h0C3);

      // R5 attribute write keeps byte
      host_op(a, 1'b1, 1'b0, 8'hF9, lat);
      chk(rd_cell(int'({8'h5A, 6'h2B})) == 12'h9C3, "R5 attribute lanes", rd_cell(int'({8'h5A, 6'h2B})), 12'h9C3);

      // R6 reads of both widths
      host_op(a, 1'b0, 1'b1, 8'h00, lat);
      host_op(a, 1'b0, 1'b0, 8'h00, lat);

      // several patterns including corners
      for (int i = 0; i < 12; i++) begin
         automatic logic [5:0] c = (i == 0) ? 6'h00 : (i == 1) ? 6'h3F : 6'(i * 11);
         automatic logic [7:0] r = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'(i * 37 + 3);
         host_op(mk(2'b10, c, r), 1'b1, 1'b1, 8'(i * 29 + 1), lat);
         host_op(mk(2'b10, c, r), 1'b1, 1'b0, 8'(i + 5), lat);
      end
      for (int i = 0; i < 12; i++) begin
         automatic logic [5:0] c = (i == 0) ? 6'h00 : (i == 1) ? 6'h3F : 6'(i * 11);
         automatic logic [7:0] r = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'(i * 37 + 3);
         host_op(mk(2'b10, c, r), 1'b0, 1'b1, 8'h00, lat);
         host_op(mk(2'b10, c, r), 1'b0, 1'b0, 8'h00, lat);
      end

      // R2 wrong window: no completion, no column strobe, memory intact
      @(negedge clk);
      d0 = done_cnt; c0 = cas_falls;
      host_addr = mk(2'b11, 6'h2B, 8'h5A); host_wr = 1'b1; host_wide = 1'b1;
      host_wdata = 8'h11; host_req = 1'b1;
      repeat (30) @(negedge clk);
      host_req = 1'b0;
      repeat (2) @(negedge clk);
      chk(done_cnt == d0, "R2 window miss completion", done_cnt - d0, 0);
      chk(cas_falls == c0, "R2 window miss column strobe", cas_falls - c0, 0);
      host_op(a, 1'b0, 1'b1, 8'h00, lat);

      // R8 and R2: grant low, no strobes, request ignored
      @(negedge clk);
      host_grant = 1'b0;
      repeat (8) @(negedge clk);
      d0 = done_cnt; r0 = ras_falls;
      host_addr = a; host_wr = 1'b1; host_wide = 1'b1; host_wdata = 8'h22; host_req = 1'b1;
      repeat (40) @(negedge clk);
      host_req = 1'b0;
      chk(ras_falls == r0, "R8 no strobes without grant", ras_falls - r0, 0);
      chk(done_cnt == d0, "R2 no completion without grant", done_cnt - d0, 0);
      host_grant = 1'b1;
      host_op(a, 1'b0, 1'b1, 8'h00, lat);

      // R7 refresh sweep while host owns and is idle
      @(negedge clk);
      for (int i = 0; i < 256; i++) seen[i] = 1'b0;
      c0 = cas_falls;
      repeat (5200) @(negedge clk);
      begin
         automatic int n = 0;
         for (int i = 0; i < 256; i++) n += int'(seen[i]);
         chk(n == 256, "R7 all rows refreshed in window", n, 256);
      end
      chk(cas_falls == c0, "R7 refresh without column strobe", cas_falls - c0, 0);

      // data survives refresh activity
      host_op(a, 1'b0, 1'b0, 8'h00, lat);
      host_op(mk(2'b10, 6'h3F, 8'hFF), 1'b0, 1'b1, 8'h00, lat);
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R4 every request completed", exp_q.size(), 0);
      finish_run();
   end
endmodule